// File: doc/BRIEF.md
# Memory Access Ordering Issue Queue

This block sits between a load/store front end and a memory port. Requests enter in program order and wait in a small circular queue. The block may hand them to the memory port in a different order, and the port may report completions in any order. Each request has an operation kind (read, write, flush, atomic read-modify-write), an address and an ordering class (unordered, acquire, release, fence). A request counts as visible once its completion comes back on the completion input. Entries leave the queue from the oldest end, in program order, once they are visible.

Every cycle the block finds all entries that are currently allowed to go and offers the oldest of them on the issue handshake. An entry is held back for any of these reasons: an older acquire or fence that is not yet visible; its own release or fence class while any older entry is still outstanding; a same-region data hazard with an older outstanding entry; or a store-side operation that is not yet committed. A squash input removes speculative work. An atomic is sent as one request. It conflicts with every access to its region, so nothing touches that region between its read and its write.

Top module: `mem_order_queue`

## Requirements
- R1: Enqueue uses a valid/ready handshake. `enq_ready` is low exactly when 8 slots are occupied. `enq_tag` gives the slot assigned to the offered request, and successive enqueues get consecutive tags modulo 8.
- R2: After reset the queue is empty: `enq_ready` is 1 and `iss_valid` is 0.
- R3: At most one request issues per cycle, and the one offered is the oldest eligible entry. An unordered request with no hazard may issue ahead of an older blocked one.
- R4: A request with ordering class release (`2`) issues only after every older entry has completed.
- R5: While an older entry with ordering class acquire (`1`) has not completed, no younger entry issues.
- R6: A fence (`3`) both waits for all older entries to complete and blocks every younger entry until it completes itself.
- R7: Two entries conflict when their address bits above bit 5 match (same 64-byte region) and they are not both reads. Op codes: read `0`, write `1`, flush `2`, atomic `3`. A younger conflicting entry issues only after the older one completes. Two reads to one region may issue in either order.
- R8: An atomic (`3`) conflicts with every other access to its region, whatever that access's kind. No access to the region issues between the atomic's issue and its completion.
- R9: Writes, flushes and atomics issue only after their entry is committed, either by `enq_commit` at enqueue or later through `commit_valid`/`commit_tag`. Reads may issue before commit.
- R10: A squash pulse drops every entry that is uncommitted and not yet issued. A dropped entry never issues, even if it is committed afterwards, and its slot becomes free again.
- R11: Slots are freed only from the oldest end, one per cycle, and only once that entry has completed or was dropped. A completed younger entry does not free a slot while the oldest entry is still outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | A new request is offered |
| enq_ready | output | 1 | Queue can accept a request |
| enq_op | input | 2 | Operation kind of the new request |
| enq_ord | input | 2 | Ordering class of the new request |
| enq_addr | input | AW | Address of the new request |
| enq_commit | input | 1 | New request is already non-speculative |
| enq_tag | output | TW | Slot that the offered request will occupy |
| commit_valid | input | 1 | Mark an entry committed |
| commit_tag | input | TW | Entry to commit |
| squash | input | 1 | Drop uncommitted, unissued entries |
| iss_valid | output | 1 | An entry is offered to the memory port |
| iss_ready | input | 1 | Memory port accepts the offered entry |
| iss_tag | output | TW | Tag of the offered entry |
| iss_op | output | 2 | Operation kind of the offered entry |
| iss_addr | output | AW | Address of the offered entry |
| cmp_valid | input | 1 | A previously issued entry became visible |
| cmp_tag | input | TW | Tag of the completed entry |

## Verification
A corrupted issued, done or committed bit shows up at `iss_valid` in the very next cycle. The entry is then offered twice, never offered, or offered before its blocker completes, and the pairwise sweep samples exactly that cycle for every combination of kind, class and region match. A wrong head or count value shows on `enq_ready` or on the sequence of `enq_tag` values within the same cycle, so the fill, retire and squash sequences catch it one edge after the faulty update.

// File: rtl/mem_order_queue.sv
module mem_order_queue #(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  parameter int REGION_LSB = 6,
  localparam int TW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_valid,
  output logic          enq_ready,
  input  logic [1:0]    enq_op,
  input  logic [1:0]    enq_ord,
  input  logic [AW-1:0] enq_addr,
  input  logic          enq_commit,
  output logic [TW-1:0] enq_tag,
  input  logic          commit_valid,
  input  logic [TW-1:0] commit_tag,
  input  logic          squash,
  output logic          iss_valid,
  input  logic          iss_ready,
  output logic [TW-1:0] iss_tag,
  output logic [1:0]    iss_op,
  output logic [AW-1:0] iss_addr,
  input  logic          cmp_valid,
  input  logic [TW-1:0] cmp_tag
);
  localparam logic [1:0] OP_RD   = 2'd0;
  localparam logic [1:0] ORD_ACQ = 2'd1;
  localparam logic [1:0] ORD_REL = 2'd2;
  localparam logic [1:0] ORD_FEN = 2'd3;
  localparam logic [TW:0] FULL   = (TW+1)'(DEPTH);

  logic [TW-1:0]    head, pick;
  logic [TW:0]      cnt;
  logic [DEPTH-1:0] vld, issd, done, cmtd, occ, live, elig;
  logic [1:0]       op_q  [DEPTH];
  logic [1:0]       ord_q [DEPTH];
  logic [AW-1:0]    addr_q[DEPTH];
  logic [TW-1:0]    age   [DEPTH];
  logic             found, enq_fire, iss_fire, retire;

  function automatic logic same_rgn(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return a[AW-1:REGION_LSB] == b[AW-1:REGION_LSB];
  endfunction

  function automatic logic clash(input logic [1:0] oa, input logic [1:0] ob);
    return !(oa == OP_RD && ob == OP_RD);
  endfunction

  assign enq_ready = cnt != FULL;
  assign enq_tag   = head + cnt[TW-1:0];
  assign enq_fire  = enq_valid && enq_ready;
  assign iss_valid = found;
  assign iss_tag   = pick;
  assign iss_op    = op_q[pick];
  assign iss_addr  = addr_q[pick];
  assign iss_fire  = iss_valid && iss_ready;
  assign retire    = (cnt != '0) && (!vld[head] || done[head]);

  always_comb begin
    for (int s = 0; s < DEPTH; s++) begin
      age[s]  = TW'(s) - head;
      occ[s]  = {1'b0, age[s]} < cnt;
      live[s] = occ[s] && vld[s] && !done[s];
    end
  end

  always_comb begin
    for (int s = 0; s < DEPTH; s++) begin
      elig[s] = live[s] && !issd[s];
      if (!cmtd[s] && op_q[s] != OP_RD) elig[s] = 1'b0;
      for (int t = 0; t < DEPTH; t++) begin
        if (live[t] && age[t] < age[s]) begin
          if (ord_q[t] == ORD_ACQ || ord_q[t] == ORD_FEN) elig[s] = 1'b0;
          if (ord_q[s] == ORD_REL || ord_q[s] == ORD_FEN) elig[s] = 1'b0;
          if (same_rgn(addr_q[t], addr_q[s]) && clash(op_q[t], op_q[s])) elig[s] = 1'b0;
        end
      end
    end
  end

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (elig[head + TW'(k)]) begin
        found = 1'b1;
        pick  = head + TW'(k);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      cnt  <= '0;
      vld  <= '0;
      issd <= '0;
      done <= '0;
      cmtd <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (squash && vld[i] && !issd[i] && !cmtd[i]
            && !(commit_valid && commit_tag == TW'(i))
            && !(iss_fire && pick == TW'(i)))
          vld[i] <= 1'b0;
        if (commit_valid && commit_tag == TW'(i)) cmtd[i] <= 1'b1;
        if (iss_fire && pick == TW'(i)) issd[i] <= 1'b1;
        if (cmp_valid && cmp_tag == TW'(i)) done[i] <= 1'b1;
      end
      if (enq_fire) begin
        vld[enq_tag]    <= 1'b1;
        issd[enq_tag]   <= 1'b0;
        done[enq_tag]   <= 1'b0;
        cmtd[enq_tag]   <= enq_commit;
        op_q[enq_tag]   <= enq_op;
        ord_q[enq_tag]  <= enq_ord;
        addr_q[enq_tag] <= enq_addr;
      end
      head <= head + TW'(retire);
      cnt  <= cnt + (TW+1)'(enq_fire) - (TW+1)'(retire);
    end
  end

  logic [DEPTH-1:0] older_live, older_acq, older_hit;
  always_comb begin
    for (int t = 0; t < DEPTH; t++) begin
      older_live[t] = live[t] && age[t] < age[pick];
      older_acq[t]  = older_live[t] && (ord_q[t] == ORD_ACQ || ord_q[t] == ORD_FEN);
      older_hit[t]  = older_live[t] && same_rgn(addr_q[t], addr_q[pick])
                      && clash(op_q[t], op_q[pick]);
    end
  end

  assert_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL) else $error("queue occupancy above depth");

  assert_offer_fresh_R3: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (occ[pick] && vld[pick] && !issd[pick])) else $error("stale entry offered");

  assert_release_drained_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && ord_q[pick] == ORD_REL) |-> older_live == '0) else $error("release ahead of older");

  assert_acquire_barrier_R5: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> older_acq == '0) else $error("issue past pending acquire");

  assert_fence_drained_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && ord_q[pick] == ORD_FEN) |-> older_live == '0) else $error("fence ahead of older");

  assert_region_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> older_hit == '0) else $error("same-region hazard violated");

  assert_store_committed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_op != OP_RD) |-> cmtd[pick]) else $error("speculative store issued");

  assert_dropped_stays_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (squash && occ[0] && !issd[0] && !cmtd[0] && !commit_valid && !iss_fire) |=> !vld[0])
    else $error("squashed entry survived");

  assert_cmp_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |-> (occ[cmp_tag] && issd[cmp_tag] && !done[cmp_tag])) else $error("bad completion tag");
endmodule

// File: tb/mem_order_queue_tb.sv
module mem_order_queue_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enq_valid = 0, enq_commit = 0, commit_valid = 0, squash = 0, iss_ready = 0, cmp_valid = 0;
  logic [1:0]  enq_op = 0, enq_ord = 0, iss_op;
  logic [31:0] enq_addr = 0, iss_addr;
  logic [2:0]  enq_tag, commit_tag = 0, iss_tag, cmp_tag = 0;
  logic        enq_ready, iss_valid;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  mem_order_queue u_dut (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
    .enq_op(enq_op), .enq_ord(enq_ord), .enq_addr(enq_addr), .enq_commit(enq_commit),
    .enq_tag(enq_tag), .commit_valid(commit_valid), .commit_tag(commit_tag),
    .squash(squash), .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_tag(iss_tag),
    .iss_op(iss_op), .iss_addr(iss_addr), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag)
  );

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic enq(input logic [1:0] op, input logic [1:0] ord, input logic [31:0] a,
                     input bit c, output int tag);
    enq_valid = 1; enq_op = op; enq_ord = ord; enq_addr = a; enq_commit = c;
    #4; tag = int'(enq_tag);
    chk(enq_ready == 1'b1, "R1 ready before enqueue", enq_ready, 1);
    tick; enq_valid = 0;
  endtask

  task automatic issue(output bit v, output int tag);
    iss_ready = 1; #4; v = iss_valid; tag = int'(iss_tag);
    tick; iss_ready = 0;
  endtask

  task automatic complete(input int tag);
    cmp_valid = 1; cmp_tag = 3'(tag); tick; cmp_valid = 0;
  endtask

  task automatic commit(input int tag);
    commit_valid = 1; commit_tag = 3'(tag); tick; commit_valid = 0;
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "all watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int tw, tr, tr2, tx, ta, tb;
    bit v;
    int tg[8];
    tick; #4;
    chk(enq_ready == 1'b1, "R2 ready in reset", enq_ready, 1);
    chk(iss_valid == 1'b0, "R2 idle in reset", iss_valid, 0);
    tick; tick; rst_n = 1; #4;
    chk(enq_ready == 1'b1, "R2 ready after reset", enq_ready, 1);
    chk(iss_valid == 1'b0, "R2 idle after reset", iss_valid, 0);
    tick;

    // R9 / R3: uncommitted write waits, younger read overtakes it
    enq(2'd1, 2'd0, 32'h2000, 1'b0, tw);
    enq(2'd0, 2'd0, 32'h3000, 1'b1, tr);
    #4;
    chk(iss_valid && int'(iss_tag) == tr, "R9 read overtakes uncommitted write", int'(iss_tag), tr);
    tick;
    issue(v, tx);
    chk(v && tx == tr, "R3 out-of-order issue", tx, tr);
    #4; chk(iss_valid == 1'b0, "R9 write held until commit", iss_valid, 0); tick;
    commit(tw);
    #4; chk(iss_valid && int'(iss_tag) == tw, "R9 write after commit", int'(iss_tag), tw); tick;
    issue(v, tx);
    complete(tr); complete(tw); tick; tick; tick;

    // R10: squash drops speculative unissued entries
    enq(2'd2, 2'd0, 32'h4000, 1'b0, tw);
    enq(2'd0, 2'd0, 32'h5000, 1'b0, tr);
    enq(2'd0, 2'd0, 32'h6000, 1'b0, tr2);
    issue(v, tx);
    chk(v && tx == tr, "R3 oldest eligible read", tx, tr);
    squash = 1; tick; squash = 0;
    #4; chk(iss_valid == 1'b0, "R10 squashed entries not offered", iss_valid, 0); tick;
    commit(tw);
    #4; chk(iss_valid == 1'b0, "R10 late commit does not revive", iss_valid, 0); tick;
    complete(tr);
    for (int i = 0; i < 5; i++) tick;

    // R1 fill, R3 order, R11 in-order retire
    for (int k = 0; k < 8; k++) begin
      enq(2'd0, 2'd0, 32'h10000 + 32'(k) * 32'h100, 1'b1, tg[k]);
      chk(tg[k] == (tg[0] + k) % 8, "R1 consecutive tags", tg[k], (tg[0] + k) % 8);
    end
    #4; chk(enq_ready == 1'b0, "R1 full after 8", enq_ready, 0); tick;
    for (int k = 0; k < 8; k++) begin
      issue(v, tx);
      chk(v && tx == tg[k], "R3 oldest-first issue", tx, tg[k]);
    end
    for (int k = 1; k < 8; k++) complete(tg[k]);
    tick; tick;
    #4; chk(enq_ready == 1'b0, "R11 younger completions free nothing", enq_ready, 0); tick;
    complete(tg[0]);
    #4; chk(enq_ready == 1'b0, "R11 retire waits one edge", enq_ready, 0); tick;
    #4; chk(enq_ready == 1'b1, "R11 head retired", enq_ready, 1); tick;
    for (int i = 0; i < 10; i++) tick;

    // pairwise sweep: R4 R5 R6 R7 R8
    for (int oa = 0; oa < 4; oa++)
      for (int ra = 0; ra < 4; ra++)
        for (int ob = 0; ob < 4; ob++)
          for (int rb = 0; rb < 4; rb++)
            for (int sm = 0; sm < 2; sm++) begin
              bit eb;
              string why;
              eb = 1'b1; why = "R3 independent pair";
              if (ra == 1 || ra == 3) begin eb = 0; why = (ra == 3) ? "R6 fence blocks younger" : "R5 acquire blocks younger"; end
              else if (rb == 2 || rb == 3) begin eb = 0; why = (rb == 3) ? "R6 fence waits older" : "R4 release waits older"; end
              else if (sm == 1 && !(oa == 0 && ob == 0)) begin
                eb = 0; why = (oa == 3 || ob == 3) ? "R8 atomic region exclusion" : "R7 same-region hazard";
              end
              enq(2'(oa), 2'(ra), 32'h1040, 1'b1, ta);
              enq(2'(ob), 2'(rb), sm ? 32'h1078 : 32'h1080, 1'b1, tb);
              issue(v, tx);
              chk(v && tx == ta, "R3 older offered first", tx, ta);
              #4;
              chk(iss_valid == eb, why, iss_valid, eb);
              if (eb) chk(int'(iss_tag) == tb, why, int'(iss_tag), tb);
              tick;
              complete(ta);
              #4;
              chk(iss_valid && int'(iss_tag) == tb, why, int'(iss_tag), tb);
              tick;
              issue(v, tx);
              complete(tb);
              tick; tick; tick;
            end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule